// File: doc/BRIEF.md
# Complex Floating-Point Output Formatter

This block takes one signed fixed-point I/Q sample pair per valid strobe and re-encodes it for the output port. A control word picks one of three encodings. The first is a fixed-point word of 12, 16 or 24 bits, attenuated by a 4-bit scale. The second is an 8-bit mantissa with a 4-bit exponent. The third is a 12-bit mantissa with a 4-bit exponent. In the floating encodings the exponent counts right shifts. I and Q can each take their own exponent, or share one exponent set by the larger of the two. A force option makes the programmed scale the exponent. The mantissa then clips and never wraps.

The block has two pipeline stages. The first stage resolves the exponents. The second stage rounds, saturates and registers the words. Every formatted mantissa is sign-extended to the full output width.

Top module: `fmt_cplx_out`

## Requirements
- R1: `fmt_sel` selects the encoding: 2'b00 is fixed point, 2'b01 is an 8-bit mantissa and 2'b10 or 2'b11 is a 12-bit mantissa. Every output word is the signed result sign-extended to IN_W bits.
- R2: In fixed point, word length L is 12 when `len_sel` is 2'b00, 16 when it is 2'b01 and 24 when it is 2'b1x. The output is sat_L(rnd(x, scale + IN_W - L)), and both exponent outputs are 0.
- R3: rnd(x, k) is floor((x + 2^(k-1)) / 2^k), with rnd(x, 0) = x, so a discarded half rounds up. A result that rounding pushes past the word range saturates to the signed maximum or minimum.
- R4: In a floating mode without force or sharing, each lane's exponent is the smallest k in 0..15 for which rnd(x, k) fits the signed M-bit mantissa. The mantissa is rnd(x, k).
- R5: If no k up to 15 fits, the exponent is 15 and the mantissa saturates to the M-bit limit.
- R6: With `shared_exp` = 1 in a floating mode, both exponents equal the larger of the two lanes' R4 exponents. Both mantissas are sat_M(rnd(x, shared exponent)).
- R7: With `force_exp` = 1 in a floating mode, both exponents equal `scale`, whatever `shared_exp` is. Each mantissa is sat_M(rnd(x, scale)) and clips rather than wrapping.
- R8: `out_valid` is `in_valid` delayed by exactly two clock cycles. The words that go with it come from the sample taken with that strobe.
- R9: While `rst_n` is low, `out_valid`, the output words and the exponents are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | IN_W | Signed I sample |
| in_q | input | IN_W | Signed Q sample |
| fmt_sel | input | 2 | Encoding select |
| len_sel | input | 2 | Fixed-point word length select |
| shared_exp | input | 1 | One exponent for I and Q |
| force_exp | input | 1 | Use scale as exponent |
| scale | input | 4 | Scale / forced exponent |
| out_valid | output | 1 | Output strobe |
| out_i | output | IN_W | Formatted I word |
| out_q | output | IN_W | Formatted Q word |
| exp_i | output | 4 | I exponent |
| exp_q | output | 4 | Q exponent |

## Verification
The pairs are chosen so that each exponent path can be told apart from the others. Small and large magnitudes of both signs separate the per-lane exponents from the shared one, because the two lanes then need different shifts. Values that sit just below a power of two show whether rounding carries the mantissa into the next exponent. Full-scale inputs under a small forced exponent tell clipping apart from wrapping. The same inputs are also run through all three fixed-point word lengths, which shows that the rounding point moves with the word length and with the scale.

// File: rtl/fmt_cplx_pkg.sv
package fmt_cplx_pkg;
  localparam int CW = 48;
  typedef logic signed [CW-1:0] calc_t;

  // Round half up after an arithmetic right shift by k
  function automatic calc_t rnd_shift(calc_t x, int k);
    calc_t half;
    half = (k == 0) ? '0 : (calc_t'(1) <<< (k - 1));
    return (x + half) >>> k;
  endfunction

  function automatic logic fits(calc_t v, int bits);
    calc_t lim;
    lim = calc_t'(1) <<< (bits - 1);
    return (v >= -lim) && (v <= lim - 1);
  endfunction

  function automatic calc_t sat_to(calc_t v, int bits);
    calc_t lim;
    lim = calc_t'(1) <<< (bits - 1);
    if (v > lim - 1) return lim - 1;
    if (v < -lim) return -lim;
    return v;
  endfunction

  // Smallest shift in 0..15 that makes x fit the mantissa, else 15
  function automatic logic [3:0] find_exp(calc_t x, int bits);
    logic [3:0] e;
    e = 4'd15;
    for (int k = 15; k >= 0; k--) begin
      if (fits(rnd_shift(x, k), bits)) e = 4'(k);
    end
    return e;
  endfunction

  function automatic int mant_bits(logic [1:0] fmt);
    return fmt[1] ? 12 : 8;
  endfunction

  function automatic int word_bits(logic [1:0] len);
    return len[1] ? 24 : (len[0] ? 16 : 12);
  endfunction
endpackage

// File: rtl/fmt_exp_stage.sv
module fmt_exp_stage
  import fmt_cplx_pkg::*;
#(
  parameter int IN_W = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_i,
  input  logic signed [IN_W-1:0] in_q,
  input  logic [1:0]             fmt_sel,
  input  logic [1:0]             len_sel,
  input  logic                   shared_exp,
  input  logic                   force_exp,
  input  logic [3:0]             scale,
  output logic                   s1_valid,
  output logic signed [IN_W-1:0] s1_i,
  output logic signed [IN_W-1:0] s1_q,
  output logic [3:0]             s1_exp_i,
  output logic [3:0]             s1_exp_q,
  output logic [1:0]             s1_fmt,
  output logic [1:0]             s1_len,
  output logic                   s1_shared,
  output logic                   s1_force,
  output logic [3:0]             s1_scale
);
  logic [3:0] own_i, own_q, big_e, sel_i, sel_q;
  logic       is_float;

  assign is_float = (fmt_sel != 2'b00);
  assign own_i    = find_exp(calc_t'(in_i), mant_bits(fmt_sel));
  assign own_q    = find_exp(calc_t'(in_q), mant_bits(fmt_sel));
  assign big_e    = (own_i > own_q) ? own_i : own_q;

  always_comb begin
    if (!is_float) begin
      sel_i = 4'd0;
      sel_q = 4'd0;
    end else if (force_exp) begin
      sel_i = scale;
      sel_q = scale;
    end else if (shared_exp) begin
      sel_i = big_e;
      sel_q = big_e;
    end else begin
      sel_i = own_i;
      sel_q = own_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_i      <= '0;
      s1_q      <= '0;
      s1_exp_i  <= '0;
      s1_exp_q  <= '0;
      s1_fmt    <= '0;
      s1_len    <= '0;
      s1_shared <= 1'b0;
      s1_force  <= 1'b0;
      s1_scale  <= '0;
    end else begin
      s1_valid  <= in_valid;
      s1_i      <= in_i;
      s1_q      <= in_q;
      s1_exp_i  <= sel_i;
      s1_exp_q  <= sel_q;
      s1_fmt    <= fmt_sel;
      s1_len    <= len_sel;
      s1_shared <= shared_exp;
      s1_force  <= force_exp;
      s1_scale  <= scale;
    end
  end
endmodule

// File: rtl/fmt_mant_stage.sv
module fmt_mant_stage
  import fmt_cplx_pkg::*;
#(
  parameter int IN_W = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s1_valid,
  input  logic signed [IN_W-1:0] s1_i,
  input  logic signed [IN_W-1:0] s1_q,
  input  logic [3:0]             s1_exp_i,
  input  logic [3:0]             s1_exp_q,
  input  logic [1:0]             s1_fmt,
  input  logic [1:0]             s1_len,
  input  logic                   s1_shared,
  input  logic                   s1_force,
  input  logic [3:0]             s1_scale,
  output logic                   out_valid,
  output logic signed [IN_W-1:0] out_i,
  output logic signed [IN_W-1:0] out_q,
  output logic [3:0]             exp_i,
  output logic [3:0]             exp_q,
  output logic [1:0]             o_fmt,
  output logic                   o_shared,
  output logic                   o_force,
  output logic [3:0]             o_scale
);
  localparam int LANES = 2;

  logic signed [IN_W-1:0] lane_x   [LANES];
  logic [3:0]             lane_e   [LANES];
  calc_t                  lane_val [LANES];

  assign lane_x[0] = s1_i;
  assign lane_x[1] = s1_q;
  assign lane_e[0] = s1_exp_i;
  assign lane_e[1] = s1_exp_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (s1_fmt == 2'b00)
        lane_val[g] = sat_to(rnd_shift(calc_t'(lane_x[g]),
                                       int'(s1_scale) + IN_W - word_bits(s1_len)),
                             word_bits(s1_len));
      else
        lane_val[g] = sat_to(rnd_shift(calc_t'(lane_x[g]), int'(lane_e[g])),
                             mant_bits(s1_fmt));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      exp_i     <= '0;
      exp_q     <= '0;
      o_fmt     <= '0;
      o_shared  <= 1'b0;
      o_force   <= 1'b0;
      o_scale   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_i     <= lane_val[0][IN_W-1:0];
      out_q     <= lane_val[1][IN_W-1:0];
      exp_i     <= s1_exp_i;
      exp_q     <= s1_exp_q;
      o_fmt     <= s1_fmt;
      o_shared  <= s1_shared;
      o_force   <= s1_force;
      o_scale   <= s1_scale;
    end
  end
endmodule

// File: rtl/fmt_cplx_out.sv
module fmt_cplx_out #(
  parameter int IN_W = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_i,
  input  logic signed [IN_W-1:0] in_q,
  input  logic [1:0]             fmt_sel,
  input  logic [1:0]             len_sel,
  input  logic                   shared_exp,
  input  logic                   force_exp,
  input  logic [3:0]             scale,
  output logic                   out_valid,
  output logic signed [IN_W-1:0] out_i,
  output logic signed [IN_W-1:0] out_q,
  output logic [3:0]             exp_i,
  output logic [3:0]             exp_q
);
  logic                   s1_valid, s1_shared, s1_force;
  logic signed [IN_W-1:0] s1_i, s1_q;
  logic [3:0]             s1_exp_i, s1_exp_q, s1_scale;
  logic [1:0]             s1_fmt, s1_len;
  // mode of the sample now on the outputs, for the checker
  logic [1:0]             o_fmt;
  logic                   o_shared, o_force;
  logic [3:0]             o_scale;

  fmt_exp_stage #(.IN_W(IN_W)) exp_stage_i (
    .clk, .rst_n, .in_valid, .in_i, .in_q, .fmt_sel, .len_sel,
    .shared_exp, .force_exp, .scale,
    .s1_valid, .s1_i, .s1_q, .s1_exp_i, .s1_exp_q, .s1_fmt, .s1_len,
    .s1_shared, .s1_force, .s1_scale
  );

  fmt_mant_stage #(.IN_W(IN_W)) mant_stage_i (
    .clk, .rst_n, .s1_valid, .s1_i, .s1_q, .s1_exp_i, .s1_exp_q,
    .s1_fmt, .s1_len, .s1_shared, .s1_force, .s1_scale,
    .out_valid, .out_i, .out_q, .exp_i, .exp_q,
    .o_fmt, .o_shared, .o_force, .o_scale
  );
endmodule

// File: rtl/fmt_cplx_out_chk.sv
module fmt_cplx_out_chk #(
  parameter int IN_W = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic signed [IN_W-1:0] out_i,
  input logic signed [IN_W-1:0] out_q,
  input logic [3:0]             exp_i,
  input logic [3:0]             exp_q,
  input logic [1:0]             o_fmt,
  input logic                   o_shared,
  input logic                   o_force,
  input logic [3:0]             o_scale
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);  // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);  // R8
  AST_SHARED_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_fmt != 2'b00 && o_shared) |-> (exp_i == exp_q));  // R6
  AST_FORCED_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_fmt != 2'b00 && o_force) |-> (exp_i == o_scale && exp_q == o_scale));  // R7
  AST_FIXED_EXP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_fmt == 2'b00) |-> (exp_i == 4'd0 && exp_q == 4'd0));  // R2
  AST_M8_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_fmt == 2'b01) |->
      (out_i >= -128 && out_i <= 127 && out_q >= -128 && out_q <= 127));  // R1
endmodule

bind fmt_cplx_out fmt_cplx_out_chk #(.IN_W(IN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_i(out_i), .out_q(out_q), .exp_i(exp_i), .exp_q(exp_q),
  .o_fmt(o_fmt), .o_shared(o_shared), .o_force(o_force), .o_scale(o_scale)
);

// File: tb/fmt_cplx_out_tb.sv
module fmt_cplx_out_tb_top;
  localparam int IN_W = 24;
  localparam int NV = 14;
  // {fmt[57:56], len[55:54], shared[53], force[52], scale[51:48], i[47:24], q[23:0]}
  localparam logic [57:0] VEC [NV] = '{
    {2'b01, 2'b00, 1'b0, 1'b0, 4'd0, 24'sd1000,     -24'sd3},
    {2'b01, 2'b00, 1'b0, 1'b0, 4'd0, 24'sd255,      -24'sd128},
    {2'b01, 2'b00, 1'b0, 1'b0, 4'd0, -24'sd129,     24'sd127},
    {2'b10, 2'b00, 1'b0, 1'b0, 4'd0, 24'sd4095,     -24'sd70000},
    {2'b01, 2'b00, 1'b1, 1'b0, 4'd0, 24'sd1000,     -24'sd3},
    {2'b10, 2'b00, 1'b1, 1'b0, 4'd0, -24'sd2047,    24'sd900000},
    {2'b01, 2'b00, 1'b1, 1'b1, 4'd2, 24'sd1000,     -24'sd3},
    {2'b10, 2'b00, 1'b0, 1'b1, 4'd1, 24'sd8388607,  -24'sd8388608},
    {2'b01, 2'b00, 1'b0, 1'b1, 4'd9, 24'sd12345,    -24'sd255},
    {2'b00, 2'b00, 1'b0, 1'b0, 4'd0, 24'sd2048,     -24'sd2049},
    {2'b00, 2'b01, 1'b0, 1'b0, 4'd3, 24'sd100000,   -24'sd100000},
    {2'b00, 2'b10, 1'b0, 1'b0, 4'd0, -24'sd5,       24'sd777},
    {2'b00, 2'b11, 1'b1, 1'b1, 4'd2, 24'sd6,        -24'sd6},
    {2'b11, 2'b00, 1'b0, 1'b0, 4'd0, 24'sd4095,     -24'sd70000}
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [IN_W-1:0] in_i = '0, in_q = '0;
  logic [1:0] fmt_sel = '0, len_sel = '0;
  logic shared_exp = 1'b0, force_exp = 1'b0;
  logic [3:0] scale = '0;
  logic out_valid;
  logic signed [IN_W-1:0] out_i, out_q;
  logic [3:0] exp_i, exp_q;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fmt_cplx_out #(.IN_W(IN_W)) dut_i (.*);

  // ---- independent model (longint arithmetic, incremental search) ----
  function automatic longint m_rnd(longint x, int k);
    if (k == 0) return x;
    return (x + (64'sd1 <<< (k - 1))) >>> k;
  endfunction
  function automatic bit m_fit(longint v, int b);
    return (v < (64'sd1 <<< (b - 1))) && (v >= -(64'sd1 <<< (b - 1)));
  endfunction
  function automatic longint m_clip(longint v, int b);
    longint top = (64'sd1 <<< (b - 1)) - 1;
    if (v > top) return top;
    if (v < -top - 1) return -top - 1;
    return v;
  endfunction
  function automatic int m_exp(longint x, int b);
    int k = 0;
    while (k < 15 && !m_fit(m_rnd(x, k), b)) k++;
    return k;
  endfunction

  task automatic check(string req, bit ok, string got, string want);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %s expected %s", req, got, want);
    end
  endtask

  task automatic apply(logic [57:0] v);
    @(negedge clk);
    {fmt_sel, len_sel, shared_exp, force_exp, scale, in_i, in_q} = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_and_check(logic [57:0] v, string req);
    longint xi, xq, wi, wq;
    int ei, eq, mb, lb;
    apply(v);
    xi = longint'($signed(v[47:24]));
    xq = longint'($signed(v[23:0]));
    mb = (v[57]) ? 12 : 8;
    lb = v[55] ? 24 : (v[54] ? 16 : 12);
    if (v[57:56] == 2'b00) begin
      ei = 0; eq = 0;
      wi = m_clip(m_rnd(xi, int'(v[51:48]) + IN_W - lb), lb);
      wq = m_clip(m_rnd(xq, int'(v[51:48]) + IN_W - lb), lb);
    end else begin
      if (v[52]) begin
        ei = int'(v[51:48]); eq = ei;
      end else begin
        ei = m_exp(xi, mb); eq = m_exp(xq, mb);
        if (v[53]) begin
          if (eq > ei) ei = eq;
          eq = ei;
        end
      end
      wi = m_clip(m_rnd(xi, ei), mb);
      wq = m_clip(m_rnd(xq, eq), mb);
    end
    check(req, out_valid && longint'(out_i) == wi && longint'(out_q) == wq &&
          int'(exp_i) == ei && int'(exp_q) == eq,
          $sformatf("v=%0b i=%0d q=%0d ei=%0d eq=%0d", out_valid, out_i, out_q, exp_i, exp_q),
          $sformatf("v=1 i=%0d q=%0d ei=%0d eq=%0d", wi, wq, ei, eq));
  endtask

  function automatic string tag_of(logic [57:0] v);
    if (v[57:56] == 2'b00) return "R2";
    if (v[52]) return "R7";
    if (v[53]) return "R6";
    return "R4";
  endfunction

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", !out_valid && out_i == 0 && out_q == 0 && exp_i == 0 && exp_q == 0,
          $sformatf("v=%0b i=%0d q=%0d", out_valid, out_i, out_q), "all zero");
    rst_n = 1'b1;

    // main table (covers R1 via 2'b11 entry, R2, R4, R6, R7)
    for (int n = 0; n < NV; n++) run_and_check(VEC[n], (n == NV - 1) ? "R1" : tag_of(VEC[n]));

    // R3: fixed 12-bit, full-scale input rounds past the maximum and saturates
    run_and_check({2'b00, 2'b00, 1'b0, 1'b0, 4'd0, 24'sd8388607, -24'sd8388608}, "R3");
    // R3: exact half rounds up (2048 >> 12 with half = 0.5 -> 1; -2048 -> 0)
    run_and_check({2'b00, 2'b00, 1'b0, 1'b0, 4'd0, 24'sd2048, -24'sd2048}, "R3");
    // R5: 8-bit mantissa, no shift up to 15 fits -> exp 15, clipped
    run_and_check({2'b01, 2'b00, 1'b0, 1'b0, 4'd0, 24'sd8388607, -24'sd8388608}, "R5");

    // R8: latency of exactly two cycles
    @(negedge clk);
    {fmt_sel, len_sel, shared_exp, force_exp, scale} = '0;
    in_i = 24'sd4096; in_q = 24'sd0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", !out_valid, $sformatf("%0b", out_valid), "0 after one cycle");
    @(negedge clk);
    check("R8", out_valid && out_i == 24'sd1, $sformatf("v=%0b i=%0d", out_valid, out_i), "v=1 i=1");
    @(negedge clk);
    check("R8", !out_valid, $sformatf("%0b", out_valid), "0 after strobe drops");

    // R9: reset clears a valid output
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R9", !out_valid && out_i == 0 && exp_i == 0, $sformatf("v=%0b i=%0d", out_valid, out_i), "zero in reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule